// File: doc/BRIEF.md
# Parallel-In Serial-Out Shift Register with Clock Inhibit

This block is an eight-stage shift register. Its stages can be filled all at once from a parallel word and are read out one bit at a time from the last stage, with both a true and an inverted copy of that bit. A low level on the load control copies the parallel word into the stages. The register shifts on a rising edge of either the shift clock or the inhibit line, provided the other line is low at the time.

The block runs on a fast free-running system clock. The shift clock and inhibit lines are slow external signals. Each passes through its own synchronizer chain. The two synchronized lines are ORed, and a rising edge of that OR produces a one-cycle shift strobe. The load control and the serial input are sampled directly on the system clock. The parallel word is indexed so that bit 0 is the first stage, which takes the serial input, and the highest bit is the last stage, which drives the outputs.

Top module: `pload_shreg`

## Requirements
- R1: A synchronous reset clears every stage and the edge history, so after reset `q_true` is 0 and `q_comp` is 1.
- R2: While `load_n` is 0, the stages take `par_in` on every system clock. Bit 0 goes to the first stage and bit STAGES-1 to the last. `q_true` shows `par_in[STAGES-1]` one clock after it is sampled.
- R3: While `load_n` is 0, the values of `sclk`, `inh` and `ser_in` have no effect on the stages.
- R4: With `load_n` at 1 and `inh` at 0, a rising edge of `sclk` moves every stage one place toward the last stage and puts `ser_in` into the first stage.
- R5: With `load_n` at 1 and `sclk` at 0, a rising edge of `inh` causes the same single shift.
- R6: With `load_n` at 1, the stages hold while neither line rises. A falling edge has no effect. A rising edge of one line while the other is high has no effect.
- R7: `q_comp` is always the inverse of `q_true`.
- R8: Each qualifying edge gives exactly one shift, however long the line stays high. The new output appears on the third system clock edge after the edge is driven.
- R9: Releasing `load_n` while `sclk` or `inh` is already high causes no shift.
- R10: After the word A..H = 1,0,1,0,1,0,1,1 is loaded, the output first shows H. Later shifts then show G, F, E down to A, followed by the serial bits in the order they were shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load when 0, shift/hold when 1 |
| sclk | input | 1 | External shift clock, asynchronous |
| inh | input | 1 | Clock inhibit, acts as a second shift clock |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | STAGES | Parallel data, bit 0 = first stage |
| q_true | output | 1 | Last stage |
| q_comp | output | 1 | Inverse of the last stage |

## Verification
A parallel load and a shift edge can fall in the same cycle. The bench provokes this by raising the shift clock and the inhibit line and toggling the serial input while the load control is low. It judges the result by checking that the output follows only the parallel word. It then releases the load while the OR of the two lines is still high and confirms that the output does not change over several cycles. Only a later, genuine rising edge advances the register.

// File: rtl/pload_shreg.sv
module pload_shreg #(
  parameter int STAGES      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              sclk,
  input  logic              inh,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic              q_true,
  output logic              q_comp
);
  localparam int LAST = STAGES - 1;
  localparam int SMSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_sync, inh_sync;
  logic                   trig, trig_q, shift_stb;
  logic [STAGES-1:0]      stages;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sync <= '0;
      inh_sync  <= '0;
    end else begin
      sclk_sync <= {sclk_sync[SMSB-1:0], sclk};
      inh_sync  <= {inh_sync[SMSB-1:0], inh};
    end
  end

  assign trig      = sclk_sync[SMSB] | inh_sync[SMSB];
  assign shift_stb = load_n & trig & ~trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig;
  end

  always_ff @(posedge clk) begin
    if (rst)            stages <= '0;
    else if (!load_n)   stages <= par_in;
    else if (shift_stb) stages <= {stages[LAST-1:0], ser_in};
  end

  assign q_true = stages[LAST];
  assign q_comp = ~stages[LAST];
endmodule

// File: rtl/pload_shreg_chk.sv
module pload_shreg_chk #(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              load_n,
  input logic              ser_in,
  input logic [STAGES-1:0] par_in,
  input logic              q_true,
  input logic              q_comp,
  input logic              shift_stb,
  input logic [STAGES-1:0] stages
);
  a_r1_reset_out: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!q_true && q_comp));

  a_r2_load_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_n)) |-> (q_true == $past(par_in[STAGES-1])));

  a_r4_shift_moves: assert property (@(posedge clk) disable iff (rst)
    shift_stb |=> (q_true == $past(stages[STAGES-2])));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n && !shift_stb) |=> $stable(stages));

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
    shift_stb |=> !shift_stb);

  a_r7_comp_out: assert property (@(posedge clk) disable iff (rst)
    $past(q_true) != $past(q_comp));
endmodule

bind pload_shreg pload_shreg_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst), .load_n(load_n), .ser_in(ser_in), .par_in(par_in),
  .q_true(q_true), .q_comp(q_comp), .shift_stb(shift_stb), .stages(stages)
);

// File: tb/tb_pload_shreg.sv
module tb_pload_shreg;
  localparam int PERIOD = 10;
  localparam int NVEC   = 12;
  // vector: {op[1:0] (0 load, 1 sclk pulse, 2 inh pulse), data[7:0], ser, expected q}
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd0, 8'hD5, 1'b0, 1'b1},
    {2'd1, 8'h00, 1'b1, 1'b1},
    {2'd2, 8'h00, 1'b0, 1'b0},
    {2'd1, 8'h00, 1'b1, 1'b1},
    {2'd2, 8'h00, 1'b1, 1'b0},
    {2'd1, 8'h00, 1'b0, 1'b1},
    {2'd1, 8'h00, 1'b0, 1'b0},
    {2'd2, 8'h00, 1'b0, 1'b1},
    {2'd1, 8'h00, 1'b0, 1'b1},
    {2'd2, 8'h00, 1'b0, 1'b0},
    {2'd1, 8'h00, 1'b0, 1'b1},
    {2'd1, 8'h00, 1'b0, 1'b1}
  };

  logic clk = 0, rst = 1, load_n = 1, sclk = 0, inh = 0, ser_in = 0;
  logic [7:0] par_in = '0;
  logic q_true, q_comp;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  pload_shreg dut (.clk(clk), .rst(rst), .load_n(load_n), .sclk(sclk), .inh(inh),
                   .ser_in(ser_in), .par_in(par_in), .q_true(q_true), .q_comp(q_comp));

  always #(PERIOD/2) clk = ~clk;

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (q_true !== exp || q_comp !== ~exp) begin
      n_fail++;
      $display("FAIL %s: q_true=%b q_comp=%b expected %b/%b", req, q_true, q_comp, exp, ~exp);
    end
  endtask

  task automatic do_load(input logic [7:0] d);
    load_n = 0; par_in = d; wait_n(2);
    load_n = 1; wait_n(2);
  endtask

  task automatic pulse_sclk(input logic s);
    ser_in = s; sclk = 1; wait_n(4);
    sclk = 0; wait_n(3);
  endtask

  task automatic pulse_inh(input logic s);
    ser_in = s; inh = 1; wait_n(4);
    inh = 0; wait_n(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    check("R1 reset", 1'b0);
    rst = 0; wait_n(1);
    check("R1 after release", 1'b0);

    // R10 / R4 / R5 / R7 table walk
    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v][11:10])
        2'd0: do_load(VEC[v][9:2]);
        2'd1: pulse_sclk(VEC[v][1]);
        default: pulse_inh(VEC[v][1]);
      endcase
      check($sformatf("R10 vector %0d", v), VEC[v][0]);
    end

    // R2 / R3: load wins over sclk, inh and ser_in
    load_n = 0; par_in = 8'h40; wait_n(2);
    check("R2 load G only", 1'b0);
    sclk = 1; inh = 1; ser_in = 1; wait_n(2); ser_in = 0; wait_n(3);
    check("R3 clock lines ignored during load", 1'b0);
    par_in = 8'h80; wait_n(2);
    check("R2 follows par_in each cycle", 1'b1);
    par_in = 8'h40; wait_n(2);
    check("R2 follows par_in back", 1'b0);
    inh = 0; wait_n(3);
    // R9: release load with sclk still high
    load_n = 1; wait_n(6);
    check("R9 no shift on load release", 1'b0);
    // R6: inh rising while sclk high, then falling edges
    pulse_inh(1'b1);
    check("R6 inh edge with sclk high", 1'b0);
    sclk = 0; wait_n(4);
    check("R6 falling edge no shift", 1'b0);
    pulse_sclk(1'b0);
    check("R4 sclk edge shifts G to H", 1'b1);
    pulse_inh(1'b0);
    check("R5 inh edge shifts", 1'b0);

    // R8: latency and single shift per edge
    do_load(8'hA0);
    check("R8 loaded H", 1'b1);
    sclk = 1; ser_in = 0;
    wait_n(2);
    check("R8 unchanged after two edges", 1'b1);
    wait_n(1);
    check("R8 shifted on third edge", 1'b0);
    wait_n(8);
    check("R8 only one shift while held", 1'b0);
    sclk = 0; wait_n(4);

    // R1: reset mid-run
    do_load(8'hFF);
    check("R1 pre-reset state", 1'b1);
    rst = 1; wait_n(2);
    check("R1 reset clears stages", 1'b0);
    rst = 0; wait_n(2);
    check("R1 stays clear", 1'b0);

    finish_run();
  end
endmodule